// File: doc/BRIEF.md
# Tiny 8-bit four-register CPU

A small multi-cycle processor core built around an 8-bit datapath. It has four general registers, an 8-bit program counter and a single 256-byte address space. Code and data share that space. Every instruction is exactly one byte. Execution starts at address 0 after reset. The core fetches one byte, decodes it and executes it, then moves on to the next byte. The instruction set covers:

- register copy and exchange;
- logical shifts by a constant;
- add, subtract, xor, and, invert and increment;
- byte load and store;
- a short PC-relative branch that is taken when r0 is non-zero;
- halt.

The memory sits outside the core as a synchronous RAM. An address placed on `mem_addr` returns its byte on `mem_rdata` one clock later. A byte input port with a valid/ready handshake feeds the input instruction. A byte output port with a one-cycle strobe carries the output instruction.

For two-register encodings, bits [3:2] name the source register A and bits [1:0] name the destination register B. The result always lands in B.

Top module: `tiny_cpu8`

## Requirements
- R1: Reset clears all four registers and the PC. It holds `halted`, `out_valid`, `in_ready` and `mem_we` low, and the first fetch reads address 0.
- R2: A byte 000ooooo is a branch. If r0 is non-zero, the next PC is PC+1+ooooo−16 (mod 256), which reaches −16..+15 from the next instruction. Otherwise execution continues at PC+1.
- R3: 0010AABB copies rA into rB. 0011AABB exchanges rA and rB.
- R4: 010RRSSS shifts rR left by SSS bits and 011RRSSS shifts it right by SSS bits. Both are logical shifts with zero fill, kept to 8 bits.
- R5: 1000AABB sets rB to rB+rA and 1001AABB sets rB to rB−rA. Both wrap modulo 256.
- R6: 1010AABB sets rB to rB^rA and 1011AABB sets rB to rB&rA.
- R7: 1100AABB loads the byte at address rA into rB. 1101AABB writes rB to address rA.
- R8: 111010RR inverts rR bitwise. 111100RR adds one to rR, wrapping from 0xFF to 0x00.
- R9: 111000RR raises `in_ready` and stalls until `in_valid` is seen with it. The core then writes `in_data` into rR.
- R10: 111001RR drives rR on `out_data` with `out_valid` high for exactly one cycle.
- R11: The bytes 0xEC–0xEF and 0xF4–0xFE change no register and produce no output.
- R12: 0xFF halts the core. `halted` then stays high and the core does no further store, input or output until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 8 | RAM address for fetch, load and store |
| mem_we | output | 1 | RAM write strobe |
| mem_wdata | output | 8 | RAM write byte |
| mem_rdata | input | 8 | RAM read byte, valid one cycle after the address |
| in_data | input | 8 | Input port byte |
| in_valid | input | 1 | Input byte available |
| in_ready | output | 1 | Core waiting on the input instruction |
| out_data | output | 8 | Output port byte |
| out_valid | output | 1 | One-cycle strobe qualifying `out_data` |
| halted | output | 1 | Core has executed halt |

## Verification
The bench builds the core with the package defaults: an 8-bit word, four registers and a branch bias of 16. These are the only values for which the one-byte encodings are defined.

At these defaults, the bench can reach:

- the full branch reach, both +15 and −16;
- wrap-around of add, subtract and increment;
- shifts by 0, by 3 and by 5;
- a load from the top byte of memory.

Each short program is written into the RAM model. The bench predicts the byte sequence the program must emit on the output port and the final RAM contents.

// File: rtl/tcpu_pkg.sv
package tcpu_pkg;
  localparam int WORD_W  = 8;
  localparam int ADDR_W  = WORD_W;
  localparam int REG_N   = 4;
  localparam int REG_W   = $clog2(REG_N);
  localparam int SH_W    = 3;
  localparam int OFF_W   = 5;
  localparam int BR_BIAS = 16;

  typedef enum logic [4:0] {
    OP_BR, OP_MOV, OP_SWP, OP_SHL, OP_SHR, OP_ADD, OP_SUB, OP_XOR, OP_AND,
    OP_LDB, OP_STB, OP_INP, OP_OUT, OP_NOT, OP_INC, OP_NOP, OP_HLT
  } op_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_LOAD, ST_HALT
  } state_e;

  typedef struct packed {
    op_e              op;
    logic [REG_W-1:0] ra;
    logic [REG_W-1:0] rb;
    logic [SH_W-1:0]  sh;
    logic [OFF_W-1:0] off;
  } dec_t;

  // Result written to the destination register; src = rA, dst = rB.
  function automatic logic [WORD_W-1:0] alu_calc(op_e op, logic [WORD_W-1:0] src,
                                                 logic [WORD_W-1:0] dst, logic [SH_W-1:0] sh);
    logic [WORD_W-1:0] y;
    case (op)
      OP_MOV, OP_SWP: y = src;
      OP_SHL:         y = dst << sh;
      OP_SHR:         y = dst >> sh;
      OP_ADD:         y = dst + src;
      OP_SUB:         y = dst - src;
      OP_XOR:         y = dst ^ src;
      OP_AND:         y = dst & src;
      OP_NOT:         y = ~dst;
      OP_INC:         y = dst + WORD_W'(1);
      default:        y = dst;
    endcase
    return y;
  endfunction

  // Branch target relative to the byte after the branch, offset biased.
  function automatic logic [ADDR_W-1:0] br_target(logic [ADDR_W-1:0] pc, logic [OFF_W-1:0] off);
    return pc + ADDR_W'(1) + ADDR_W'(off) - ADDR_W'(BR_BIAS);
  endfunction
endpackage

// File: rtl/tcpu_decode.sv
module tcpu_decode
  import tcpu_pkg::*;
(
  input  logic [WORD_W-1:0] ir,
  output dec_t              dec
);
  always_comb begin
    dec.op  = OP_NOP;
    dec.ra  = ir[3:2];
    dec.rb  = ir[1:0];
    dec.sh  = ir[2:0];
    dec.off = ir[4:0];
    casez (ir)
      8'b000?????: dec.op = OP_BR;
      8'b0010????: dec.op = OP_MOV;
      8'b0011????: dec.op = OP_SWP;
      8'b010?????: begin dec.op = OP_SHL; dec.rb = ir[4:3]; end
      8'b011?????: begin dec.op = OP_SHR; dec.rb = ir[4:3]; end
      8'b1000????: dec.op = OP_ADD;
      8'b1001????: dec.op = OP_SUB;
      8'b1010????: dec.op = OP_XOR;
      8'b1011????: dec.op = OP_AND;
      8'b1100????: dec.op = OP_LDB;
      8'b1101????: dec.op = OP_STB;
      8'b111000??: dec.op = OP_INP;
      8'b111001??: dec.op = OP_OUT;
      8'b111010??: dec.op = OP_NOT;
      8'b111100??: dec.op = OP_INC;
      8'b11111111: dec.op = OP_HLT;
      default:     dec.op = OP_NOP;
    endcase
  end
endmodule

// File: rtl/tcpu_regfile.sv
module tcpu_regfile
  import tcpu_pkg::*;
#(
  parameter int N = REG_N,
  parameter int W = WORD_W,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b,
  output logic [W-1:0]  r0,
  input  logic          we0,
  input  logic [AW-1:0] waddr0,
  input  logic [W-1:0]  wdata0,
  input  logic          we1,
  input  logic [AW-1:0] waddr1,
  input  logic [W-1:0]  wdata1
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (we1 && waddr1 == AW'(i))      regs[i] <= wdata1;
        else if (we0 && waddr0 == AW'(i)) regs[i] <= wdata0;
      end
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
  assign r0      = regs[0];

  // Dual writes (exchange) must not lose a value to the port priority.
  AST_SWAP_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (we0 && we1) |-> (waddr0 != waddr1 || wdata0 == wdata1)); // R3
endmodule

// File: rtl/tcpu_alu.sv
module tcpu_alu
  import tcpu_pkg::*;
(
  input  op_e               op,
  input  logic [WORD_W-1:0] src,
  input  logic [WORD_W-1:0] dst,
  input  logic [SH_W-1:0]   sh,
  output logic [WORD_W-1:0] y
);
  assign y = alu_calc(op, src, dst, sh);
endmodule

// File: rtl/tiny_cpu8.sv
module tiny_cpu8
  import tcpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid,
  output logic              halted
);
  state_e            state;
  logic [ADDR_W-1:0] pc;
  logic [WORD_W-1:0] ir;
  dec_t              dec;
  logic [WORD_W-1:0] rd_a, rd_b, r0, alu_y;
  logic              wr0_en, wr1_en;
  logic [WORD_W-1:0] wr0_data;

  // Named internal events
  logic ev_exec, ev_br, ev_br_taken, ev_mem, ev_store, ev_out, ev_inp_wait, ev_inp_take, ev_halt;
  assign ev_exec     = (state == ST_EXEC);
  assign ev_br       = ev_exec && dec.op == OP_BR;
  assign ev_br_taken = ev_br && r0 != '0;
  assign ev_mem      = ev_exec && (dec.op == OP_LDB || dec.op == OP_STB);
  assign ev_store    = ev_exec && dec.op == OP_STB;
  assign ev_out      = ev_exec && dec.op == OP_OUT;
  assign ev_inp_wait = ev_exec && dec.op == OP_INP;
  assign ev_inp_take = ev_inp_wait && in_valid;
  assign ev_halt     = ev_exec && dec.op == OP_HLT;

  tcpu_decode u_dec (.ir(ir), .dec(dec));

  tcpu_alu u_alu (.op(dec.op), .src(rd_a), .dst(rd_b), .sh(dec.sh), .y(alu_y));

  always_comb begin
    wr0_en   = 1'b0;
    wr0_data = alu_y;
    if (state == ST_LOAD) begin
      wr0_en   = 1'b1;
      wr0_data = mem_rdata;
    end else if (ev_exec) begin
      case (dec.op)
        OP_MOV, OP_SWP, OP_SHL, OP_SHR, OP_ADD, OP_SUB,
        OP_XOR, OP_AND, OP_NOT, OP_INC: wr0_en = 1'b1;
        OP_INP: begin wr0_en = in_valid; wr0_data = in_data; end
        default: wr0_en = 1'b0;
      endcase
    end
  end
  assign wr1_en = ev_exec && dec.op == OP_SWP;

  tcpu_regfile u_rf (
    .clk(clk), .rst_n(rst_n),
    .raddr_a(dec.ra), .raddr_b(dec.rb), .rdata_a(rd_a), .rdata_b(rd_b), .r0(r0),
    .we0(wr0_en), .waddr0(dec.rb), .wdata0(wr0_data),
    .we1(wr1_en), .waddr1(dec.ra), .wdata1(rd_b)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_FETCH;
      pc        <= '0;
      ir        <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= ev_out;
      if (ev_out) out_data <= rd_b;
      case (state)
        ST_FETCH:  state <= ST_DECODE;
        ST_DECODE: begin ir <= mem_rdata; state <= ST_EXEC; end
        ST_EXEC: begin
          if (ev_halt) state <= ST_HALT;
          else if (ev_inp_wait && !in_valid) state <= ST_EXEC;
          else begin
            state <= (dec.op == OP_LDB) ? ST_LOAD : ST_FETCH;
            pc    <= ev_br_taken ? br_target(pc, dec.off) : pc + ADDR_W'(1);
          end
        end
        ST_LOAD:  state <= ST_FETCH;
        default:  state <= ST_HALT;
      endcase
    end
  end

  assign mem_addr  = ev_mem ? rd_a : pc;
  assign mem_we    = ev_store;
  assign mem_wdata = rd_b;
  assign in_ready  = ev_inp_wait;
  assign halted    = (state == ST_HALT);

  AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_br && r0 == '0) |=> (pc == $past(pc) + ADDR_W'(1))); // R2
  AST_INP_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready); // R9
  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R10
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc))); // R12
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_we && !in_ready && !out_valid)); // R12
endmodule

// File: tb/tiny_cpu8_tb.sv
module tiny_cpu8_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata, in_data, out_data;
  logic       mem_we, in_valid, in_ready, out_valid, halted;

  always #5 clk = ~clk;

  tiny_cpu8 u_dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .halted(halted)
  );

  // Synchronous RAM model
  logic [7:0] ram [256];
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  int n_vec = 0, n_bad = 0, cyc = 0, wp = 0, gap = 3;
  logic [7:0] exp_q[$];
  string      exp_tag[$];
  logic [7:0] in_q[$];
  bit stall_prev = 0, took = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_out(input logic [7:0] v, input string req);
    exp_q.push_back(v);
    exp_tag.push_back(req);
  endtask

  // Monitor: pops the scoreboard on each output strobe
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected output", out_data, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        chk(out_data == e, t, out_data, e);
      end
    end
  end

  // Input feeder with gaps; also checks that the core keeps waiting
  always @(negedge clk) begin
    if (!rst_n) begin
      stall_prev = 0; took = 0; in_valid = 0; gap = 3;
    end else begin
      if (stall_prev) chk(in_ready, "R9 stall held", in_ready, 1);
      if (took) begin
        void'(in_q.pop_front());
        in_valid = 0; took = 0; gap = 3;
      end
      if (!in_valid && in_q.size() > 0) begin
        if (gap > 0) gap--;
        else begin in_data = in_q[0]; in_valid = 1; end
      end
      stall_prev = in_ready && !in_valid;
      took = in_valid && in_ready;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  // Encoders written from the requirement text
  function automatic logic [7:0] e_rr(input logic [3:0] hi, input int a, input int b);
    return {hi, 2'(a), 2'(b)};
  endfunction
  function automatic logic [7:0] e_sh(input bit right, input int r, input int s);
    return {2'b01, right, 2'(r), 3'(s)};
  endfunction
  function automatic logic [7:0] e_one(input logic [5:0] grp, input int r);
    return {grp, 2'(r)};
  endfunction
  function automatic logic [7:0] e_br(input int rel);
    return {3'b000, 5'(rel + 16)};
  endfunction

  localparam logic [5:0] G_INP = 6'b111000, G_OUT = 6'b111001, G_NOT = 6'b111010, G_INC = 6'b111100;
  localparam logic [3:0] H_MOV = 4'h2, H_SWP = 4'h3, H_ADD = 4'h8, H_SUB = 4'h9,
                         H_XOR = 4'hA, H_AND = 4'hB, H_LDB = 4'hC, H_STB = 4'hD;

  task automatic put(input logic [7:0] b);
    ram[wp] = b;
    wp++;
  endtask

  task automatic begin_prog();
    @(negedge clk);
    rst_n = 0;
    for (int i = 0; i < 256; i++) ram[i] = 8'hFF;
    wp = 0;
  endtask

  task automatic run_prog(input string name);
    logic [7:0] a;
    @(negedge clk);
    chk(mem_addr == 8'h00 && !halted && !out_valid && !in_ready && !mem_we,
        "R1 reset state", {halted, out_valid, in_ready, mem_we, mem_addr}, 0);
    rst_n = 1;
    for (int c = 0; c < 5000 && !halted; c++) @(negedge clk);
    chk(halted, {"R12 halted ", name}, halted, 1);
    chk(exp_q.size() == 0, {"R10 outputs missing ", name}, exp_q.size(), 0);
    a = mem_addr;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (mem_we || !halted) chk(1'b0, "R12 activity after halt", {mem_we, halted}, 1);
    end
    chk(mem_addr == a && halted, "R12 state frozen", mem_addr, a);
  endtask

  initial begin
    in_valid = 0; in_data = 0;
    repeat (3) @(negedge clk);

    // Program 1: data path
    begin_prog();
    ram[8'hFF] = 8'h5C;
    ram[8'hFE] = 8'hB7;
    put(e_one(G_OUT, 0)); expect_out(8'h00, "R1 r0 cleared");
    put(e_one(G_OUT, 3)); expect_out(8'h00, "R1 r3 cleared");
    put(e_one(G_NOT, 3));                       // r3 = FF
    put(e_rr(H_LDB, 3, 0));                     // r0 = 5C
    put(e_one(G_INC, 2));                       // r2 = 1
    put(e_rr(H_SUB, 2, 3));                     // r3 = FE
    put(e_rr(H_LDB, 3, 1));                     // r1 = B7
    put(e_one(G_OUT, 0)); expect_out(8'h5C, "R7 load top byte");
    put(e_one(G_OUT, 1)); expect_out(8'hB7, "R7 load");
    put(e_rr(H_MOV, 0, 2)); put(e_rr(H_ADD, 1, 2)); put(e_one(G_OUT, 2)); expect_out(8'h13, "R5 add wrap");
    put(e_rr(H_MOV, 0, 2)); put(e_rr(H_SUB, 1, 2)); put(e_one(G_OUT, 2)); expect_out(8'hA5, "R5 sub borrow");
    put(e_rr(H_MOV, 0, 2)); put(e_rr(H_XOR, 1, 2)); put(e_one(G_OUT, 2)); expect_out(8'hEB, "R6 xor");
    put(e_rr(H_MOV, 0, 2)); put(e_rr(H_AND, 1, 2)); put(e_one(G_OUT, 2)); expect_out(8'h14, "R6 and");
    put(e_rr(H_MOV, 0, 2)); put(e_one(G_NOT, 2));   put(e_one(G_OUT, 2)); expect_out(8'hA3, "R8 not");
    put(e_rr(H_MOV, 1, 2)); put(e_one(G_INC, 2));   put(e_one(G_OUT, 2)); expect_out(8'hB8, "R8 inc");
    put(e_rr(H_XOR, 2, 2)); put(e_one(G_NOT, 2)); put(e_one(G_INC, 2)); put(e_one(G_OUT, 2));
    expect_out(8'h00, "R8 inc wrap");
    put(e_rr(H_MOV, 0, 2)); put(e_sh(0, 2, 3)); put(e_one(G_OUT, 2)); expect_out(8'hE0, "R4 shl 3");
    put(e_rr(H_MOV, 1, 2)); put(e_sh(1, 2, 5)); put(e_one(G_OUT, 2)); expect_out(8'h05, "R4 shr 5");
    put(e_rr(H_MOV, 1, 2)); put(e_sh(0, 2, 0)); put(e_one(G_OUT, 2)); expect_out(8'hB7, "R4 shift 0");
    put(e_rr(H_SWP, 0, 1));
    put(e_one(G_OUT, 0)); expect_out(8'hB7, "R3 swap rA");
    put(e_one(G_OUT, 1)); expect_out(8'h5C, "R3 swap rB");
    put(8'hEC); put(8'hF7); put(8'hFE);
    put(e_one(G_OUT, 0)); expect_out(8'hB7, "R11 no-op r0");
    put(e_one(G_OUT, 1)); expect_out(8'h5C, "R11 no-op r1");
    put(e_rr(H_STB, 3, 1));                     // ram[FE] = 5C
    put(e_rr(H_XOR, 2, 2));
    put(e_rr(H_LDB, 3, 2));
    put(e_one(G_OUT, 2)); expect_out(8'h5C, "R7 store then load");
    put(8'hFF);
    run_prog("p1");
    chk(ram[8'hFE] == 8'h5C, "R7 store in RAM", ram[8'hFE], 8'h5C);

    // Program 2: input port, short branches, counted loop
    begin_prog();
    in_q.push_back(8'hC6);
    in_q.push_back(8'h03);
    put(e_one(G_INP, 1));
    put(e_one(G_OUT, 1)); expect_out(8'hC6, "R9 input captured");
    put(e_br(5));                               // r0 = 0: falls through
    put(e_one(G_OUT, 1)); expect_out(8'hC6, "R2 not taken");
    put(e_one(G_INC, 0));
    put(e_br(1));                               // skips next byte
    put(e_one(G_OUT, 0));
    put(e_one(G_INC, 3));
    put(e_one(G_INP, 0));                       // r0 = 3
    put(e_one(G_OUT, 0)); expect_out(8'h03, "R2 loop pass 1");
    expect_out(8'h02, "R2 loop pass 2");
    expect_out(8'h01, "R2 loop pass 3");
    put(e_rr(H_SUB, 3, 0));
    put(e_br(-3));
    put(8'hFF);
    run_prog("p2");

    // Program 3: extreme branch reach
    begin_prog();
    put(e_one(G_INC, 0));                       // 0
    put(e_br(15));                              // 1 -> 17
    for (int i = 2; i < 20; i++) put(e_one(G_OUT, 0));
    ram[4] = e_one(G_INC, 0);
    ram[5] = e_one(G_OUT, 0);
    ram[6] = 8'hFF;
    ram[17] = e_one(G_INC, 0);
    ram[18] = e_one(G_OUT, 0);
    ram[19] = e_br(-16);                        // 19 -> 4
    expect_out(8'h02, "R2 reach +15");
    expect_out(8'h03, "R2 reach -16");
    run_prog("p3");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule